// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After reset, this block reads an 18-word (36-byte) configuration image from a bit-serial EEPROM. It uses a single sequential read: a start bit, a two-bit read opcode and a six-bit zero address go out, and then 288 data bits come back while chip select stays high. The serial clock comes from the system clock through a divider set by a parameter. Each word arrives most significant bit first. As the words arrive, their bytes are summed modulo 256.

The image is valid only if the byte sum comes to FFh. One byte in the image is an adjust value, and it is chosen so that the sum lands on FFh. Only on a valid image does the block update the 48-bit station address and issue a burst of eight writes to the chip's 16-bit configuration registers, following a fixed map from word to register. If the image is invalid, nothing is written and an error flag is raised. Either way, a one-cycle done pulse ends the load.

A reload request received while the block is idle repeats the whole sequence. Words that are neither mapped nor part of the station address are still counted in the sum. A 16-bit sum stored in word 06h is left for software and does not gate the load.

Top module: `eeload_top`

## Requirements
- R1: While rst_n is low, ee_cs, ee_sk, cfg_we, load_done and load_err are 0 and station_addr is 0. Asserting reset in the middle of a load drops ee_cs at once.
- R2: A load starts by itself after reset is released. Each load produces exactly 297 rising edges of ee_sk with ee_cs held high the whole time, and ee_cs is low whenever the block is idle.
- R3: While ee_cs is high, each high phase and each low phase of ee_sk lasts HALF_PERIOD clock cycles.
- R4: On the first nine ee_sk rising edges, ee_di carries 1, 1, 0 and then six 0s. ee_di changes only while ee_sk is low.
- R5: ee_do is sampled at the end of every ee_sk high phase after the ninth. The first of each group of 16 data bits becomes bit 15 of word n, and the last becomes bit 0. The low byte [7:0] of word n is image byte 2n and the high byte [15:8] is byte 2n+1.
- R6: On a valid image, cfg_we is high for eight consecutive cycles after ee_cs falls. The writes go to register addresses 4, 5, 18, 2, 6, 7, 9, 22 in that order, with the data of words 08h, 09h, 0Ah, 0Bh, 0Ch, 0Dh, 0Eh and 11h.
- R7: On a valid image, station_addr[8k+7:8k] becomes image byte k for k = 0..5, so bits [7:0] hold the byte sent first on the medium. station_addr does not change while the block is idle.
- R8: An image is valid when the modulo-256 sum of all 36 bytes is FFh. On an invalid image there are no writes, station_addr keeps its previous value, and load_err goes to 1 and stays there until the next load starts.
- R9: The value of word 06h (a software-checked sum) has no effect on validity.
- R10: Words 03h–07h, 0Fh and 10h are never written to any register, so a valid load makes exactly eight writes.
- R11: load_done pulses for one cycle per load: in the cycle after the last write, or shortly after ee_cs falls on an invalid image. load_busy is high from the start of the load until load_done, and low afterwards.
- R12: reload_req received while idle starts a complete new load. reload_req received while a load is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_req | input | 1 | Request a fresh load (honoured when idle) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial command bits to EEPROM |
| ee_do | input | 1 | Serial data from EEPROM |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_addr | output | 5 | Configuration register address |
| cfg_wdata | output | 16 | Configuration register write data |
| station_addr | output | 48 | Station address, byte 0 in bits [7:0] |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle end-of-load pulse |
| load_err | output | 1 | Last load failed its checksum |

## Verification
Valid images are built from several different seeds, with the adjust byte recomputed each time. The resulting write data then shows whether the bit order and byte order inside a word are correct, and the write addresses show whether the map order is correct. One valid image carries a deliberately wrong word 06h, to show that only the 36-byte sum gates the load. Other images have a single flipped bit after the adjust value was set; these must produce no writes, an unchanged station address and the error flag. A second reload request made mid-load, and a reset asserted mid-load, show whether a running access is restarted or aborted.

// File: rtl/eeload_pkg.sv
package eeload_pkg;
  localparam int WORD_W     = 16;
  localparam int N_WORDS    = 18;
  localparam int CMD_BITS   = 9;
  localparam logic [CMD_BITS-1:0] READ_CMD = 9'b1_10_000000;
  localparam int DATA_BITS  = N_WORDS * WORD_W;
  localparam int TOTAL_BITS = CMD_BITS + DATA_BITS;
  localparam int N_STA      = 3;
  localparam int N_MAP      = 8;
  localparam int N_SLOT     = N_STA + N_MAP;
  localparam int WIDX_W     = $clog2(N_WORDS);
  localparam int MIDX_W     = $clog2(N_MAP);
  localparam int SIDX_W     = $clog2(N_SLOT);
  localparam int RADDR_W    = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_READ, ST_CHECK, ST_COMMIT, ST_FIN
  } ld_state_e;

  // image word captured into buffer slot s
  function automatic logic [WIDX_W-1:0] slot_word(input int s);
    if (s < N_STA)            return WIDX_W'(s);
    else if (s < N_SLOT - 1)  return WIDX_W'(s + 5);
    else                      return WIDX_W'(17);
  endfunction

  // register address for the m-th commit write
  function automatic logic [RADDR_W-1:0] map_reg(input logic [MIDX_W-1:0] m);
    case (m)
      3'd0:    return 5'd4;
      3'd1:    return 5'd5;
      3'd2:    return 5'd18;
      3'd3:    return 5'd2;
      3'd4:    return 5'd6;
      3'd5:    return 5'd7;
      3'd6:    return 5'd9;
      default: return 5'd22;
    endcase
  endfunction
endpackage

// File: rtl/eeload_serial.sv
module eeload_serial
  import eeload_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic do_i,
  output logic cs_o,
  output logic sk_o,
  output logic di_o,
  output logic bit_vld,
  output logic bit_val,
  output logic last
);
  localparam int DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int BIT_W = $clog2(TOTAL_BITS);

  logic             busy_q, busy_d;
  logic             sk_q, sk_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CMD_BITS-1:0] cmd_q, cmd_d;
  logic             tick, fall;

  assign tick    = busy_q && (div_q == DIV_W'(HALF_PERIOD - 1));
  assign fall    = tick && sk_q;
  assign bit_vld = fall && (bit_q >= BIT_W'(CMD_BITS));
  assign bit_val = do_i;
  assign last    = bit_vld && (bit_q == BIT_W'(TOTAL_BITS - 1));
  assign cs_o    = busy_q;
  assign sk_o    = sk_q;
  assign di_o    = busy_q && cmd_q[CMD_BITS-1];

  always_comb begin
    busy_d = busy_q;
    sk_d   = sk_q;
    div_d  = div_q;
    bit_d  = bit_q;
    cmd_d  = cmd_q;
    if (start) begin
      busy_d = 1'b1;
      sk_d   = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      cmd_d  = READ_CMD;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        sk_d  = ~sk_q;
        if (sk_q) begin
          cmd_d = {cmd_q[CMD_BITS-2:0], 1'b0};
          if (bit_q == BIT_W'(TOTAL_BITS - 1)) busy_d = 1'b0;
          else                                 bit_d  = bit_q + 1'b1;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sk_q   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      cmd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sk_q   <= sk_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      cmd_q  <= cmd_d;
    end
  end
endmodule

// File: rtl/eeload_gather.sv
module eeload_gather
  import eeload_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [7:0]        sum8,
  output logic [WORD_W-1:0] slot_q [N_SLOT]
);
  localparam int BCNT_W = $clog2(WORD_W);

  logic [WORD_W-2:0] sh_q, sh_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [7:0]        sum_q, sum_d;
  logic [WORD_W-1:0] word;
  logic              word_done;

  assign word      = {sh_q, bit_val};
  assign word_done = bit_vld && (bcnt_q == BCNT_W'(WORD_W - 1));
  assign sum8      = sum_q;

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    widx_d = widx_q;
    sum_d  = sum_q;
    if (clear) begin
      sh_d   = '0;
      bcnt_d = '0;
      widx_d = '0;
      sum_d  = '0;
    end else if (bit_vld) begin
      sh_d   = word[WORD_W-2:0];
      bcnt_d = bcnt_q + 1'b1;
      if (word_done) begin
        widx_d = widx_q + 1'b1;
        sum_d  = sum_q + word[7:0] + word[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      widx_q <= '0;
      sum_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      widx_q <= widx_d;
      sum_q  <= sum_d;
    end
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam logic [WIDX_W-1:0] SW = slot_word(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q[s] <= '0;
      else if (word_done && (widx_q == SW))   slot_q[s] <= word;
    end
  end
endmodule

// File: rtl/eeload_top.sv
module eeload_top
  import eeload_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reload_req,
  output logic                    ee_cs,
  output logic                    ee_sk,
  output logic                    ee_di,
  input  logic                    ee_do,
  output logic                    cfg_we,
  output logic [RADDR_W-1:0]      cfg_addr,
  output logic [WORD_W-1:0]       cfg_wdata,
  output logic [N_STA*WORD_W-1:0] station_addr,
  output logic                    load_busy,
  output logic                    load_done,
  output logic                    load_err
);
  localparam int STA_W = N_STA * WORD_W;

  logic [1:0]        rs_q;
  logic              rst_ni;
  ld_state_e         st_q, st_d;
  logic [MIDX_W-1:0] cidx_q, cidx_d;
  logic              err_q, err_d;
  logic [STA_W-1:0]  sta_q, sta_d;
  logic              ser_start, g_clear;
  logic              bit_vld, bit_val, ser_last;
  logic [7:0]        sum8;
  logic [WORD_W-1:0] slot_q [N_SLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  eeload_serial #(.HALF_PERIOD(HALF_PERIOD)) u_ser (
    .clk(clk), .rst_n(rst_ni), .start(ser_start), .do_i(ee_do),
    .cs_o(ee_cs), .sk_o(ee_sk), .di_o(ee_di),
    .bit_vld(bit_vld), .bit_val(bit_val), .last(ser_last)
  );

  eeload_gather u_gat (
    .clk(clk), .rst_n(rst_ni), .clear(g_clear),
    .bit_vld(bit_vld), .bit_val(bit_val),
    .sum8(sum8), .slot_q(slot_q)
  );

  always_comb begin
    st_d      = st_q;
    cidx_d    = cidx_q;
    err_d     = err_q;
    sta_d     = sta_q;
    ser_start = 1'b0;
    g_clear   = 1'b0;
    case (st_q)
      ST_IDLE:   if (reload_req) st_d = ST_LAUNCH;
      ST_LAUNCH: begin
        ser_start = 1'b1;
        g_clear   = 1'b1;
        err_d     = 1'b0;
        st_d      = ST_READ;
      end
      ST_READ:   if (ser_last) st_d = ST_CHECK;
      ST_CHECK: begin
        if (sum8 == 8'hFF) begin
          for (int s = 0; s < N_STA; s++) sta_d[s*WORD_W +: WORD_W] = slot_q[s];
          cidx_d = '0;
          st_d   = ST_COMMIT;
        end else begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end
      end
      ST_COMMIT: begin
        if (cidx_q == MIDX_W'(N_MAP - 1)) st_d = ST_FIN;
        else                              cidx_d = cidx_q + 1'b1;
      end
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LAUNCH;
      cidx_q <= '0;
      err_q  <= 1'b0;
      sta_q  <= '0;
    end else begin
      st_q   <= st_d;
      cidx_q <= cidx_d;
      err_q  <= err_d;
      sta_q  <= sta_d;
    end
  end

  assign cfg_we       = (st_q == ST_COMMIT);
  assign cfg_addr     = map_reg(cidx_q);
  assign cfg_wdata    = slot_q[SIDX_W'(N_STA) + SIDX_W'(cidx_q)];
  assign station_addr = sta_q;
  assign load_busy    = (st_q != ST_IDLE);
  assign load_done    = (st_q == ST_FIN);
  assign load_err     = err_q;
endmodule

// File: rtl/eeload_chk.sv
module eeload_chk #(
  parameter int HALF = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        cfg_we,
  input logic [47:0] station_addr,
  input logic        load_busy,
  input logic        load_done,
  input logic        load_err
);
  logic        sk_q;
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q  <= 1'b0;
      run_q <= '0;
    end else begin
      sk_q <= ee_sk;
      if (!ee_cs)              run_q <= '0;
      else if (ee_sk != sk_q)  run_q <= 16'd1;
      else                     run_q <= run_q + 16'd1;
    end
  end

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |-> !ee_cs);
  assert_sk_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && (ee_sk != sk_q) && (run_q != 16'd0)) |-> (run_q == 16'(HALF)));
  assert_sk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (!ee_cs && load_busy));
  assert_station_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |=> $stable(station_addr));
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !cfg_we);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  assert_done_after_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_we) |-> load_done);
endmodule

bind eeload_top eeload_chk #(.HALF(HALF_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .cfg_we(cfg_we),
  .station_addr(station_addr), .load_busy(load_busy),
  .load_done(load_done), .load_err(load_err)
);

// File: tb/sim_eeload_top.sv
module sim_eeload_top;
  localparam int HALF = 2;
  localparam int NW   = 18;
  localparam int NV   = 5;
  // {seed, bad_sw_sum, corrupt}
  localparam logic [17:0] VEC [NV] = '{
    {16'h1234, 1'b0, 1'b0},
    {16'hBEEF, 1'b1, 1'b0},
    {16'h0F0F, 1'b0, 1'b1},
    {16'h5A5A, 1'b0, 1'b0},
    {16'hFFFF, 1'b0, 1'b1}
  };
  localparam int EXP_REG  [8] = '{4, 5, 18, 2, 6, 7, 9, 22};
  localparam int EXP_WORD [8] = '{8, 9, 10, 11, 12, 13, 14, 17};

  logic clk = 1'b0, rst_n = 1'b0, reload_req = 1'b0, ee_do = 1'b0;
  logic ee_cs, ee_sk, ee_di, cfg_we, load_busy, load_done, load_err;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  eeload_top #(.HALF_PERIOD(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .reload_req(reload_req),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .station_addr(station_addr), .load_busy(load_busy),
    .load_done(load_done), .load_err(load_err)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] img [NW];
  logic [47:0] exp_sta = '0;
  int rises = 0, sess_rises = 0;
  logic [8:0] cmd_seen = '0, sess_cmd = '0;
  time t0 = 0, t1 = 0;
  int nw = 0, ndone = 0;
  logic [4:0]  wa [16];
  logic [15:0] wd [16];

  // EEPROM model
  initial begin
    forever begin
      @(posedge ee_cs);
      rises = 0;
      cmd_seen = '0;
      while (ee_cs) begin
        @(posedge ee_sk or negedge ee_cs);
        if (ee_cs && ee_sk) begin
          if (rises == 0) t0 = $time;
          if (rises == 1) t1 = $time;
          if (rises < 9) cmd_seen = {cmd_seen[7:0], ee_di};
          else if (rises < 297) begin
            int k;
            k = rises - 9;
            ee_do <= img[k / 16][15 - (k % 16)];
          end
          rises++;
        end
      end
      sess_rises = rises;
      sess_cmd = cmd_seen;
      ee_do <= 1'b0;
    end
  end

  // write / done monitor
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_we) begin
        wa[nw] = cfg_addr;
        wd[nw] = cfg_wdata;
        if (nw < 15) nw++;
      end
      if (load_done) ndone++;
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] seed, input bit swbad, input bit corrupt);
    logic [15:0] sw;
    logic [7:0]  s;
    for (int i = 0; i < NW; i++) img[i] = (seed * 16'(i + 3)) ^ {8'(i), 8'(i * 7)};
    sw = '0;
    for (int i = 0; i < 8; i++)
      if (i != 6) sw = sw + 16'(img[i][7:0]) + 16'(img[i][15:8]);
    img[6] = swbad ? ~sw : sw;
    s = '0;
    for (int i = 0; i < NW; i++) s = s + img[i][7:0] + img[i][15:8];
    s = s - img[16][15:8];
    img[16][15:8] = 8'hFF - s;
    if (corrupt) img[3] = img[3] ^ 16'h0100;
  endtask

  task automatic wait_done;
    int g;
    g = 0;
    while (!load_done && g < 5000) begin
      @(negedge clk);
      g++;
    end
    chk(g < 5000, "R11 load_done seen", g, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_reload;
    @(negedge clk);
    reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
  endtask

  task automatic check_load(input bit swbad, input bit corrupt);
    bit ok;
    ok = !corrupt;
    chk(sess_rises == 297, "R2 SK rising edges per load", sess_rises, 297);
    chk(ee_cs == 1'b0, "R2 CS low after load", ee_cs, 0);
    chk(sess_cmd == 9'b110000000, "R4 command bits", sess_cmd, 9'b110000000);
    chk(ndone == 1, "R11 done pulses", ndone, 1);
    chk(load_busy == 1'b0, "R11 busy low after done", load_busy, 0);
    chk(load_err == !ok, "R8 load_err", load_err, !ok);
    chk(nw == (ok ? 8 : 0), "R10 write count", nw, ok ? 8 : 0);
    if (ok) begin
      for (int m = 0; m < 8; m++) begin
        chk(wa[m] == 5'(EXP_REG[m]), "R6 write address", wa[m], EXP_REG[m]);
        chk(wd[m] == img[EXP_WORD[m]], "R5 write data word order", wd[m], img[EXP_WORD[m]]);
      end
      exp_sta = {img[2], img[1], img[0]};
      chk(station_addr == exp_sta, "R7 station address", station_addr, exp_sta);
      if (swbad) chk(load_err == 1'b0, "R9 word 06h ignored", load_err, 0);
    end else begin
      chk(station_addr == exp_sta, "R8 station kept on bad image", station_addr, exp_sta);
    end
  endtask

  initial begin
    build(VEC[0][17:2], VEC[0][1], VEC[0][0]);
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sk, cfg_we, load_done, load_err} == 5'b0, "R1 reset outputs",
        {ee_cs, ee_sk, cfg_we, load_done, load_err}, 0);
    chk(station_addr == 48'h0, "R1 reset station", station_addr, 0);
    nw = 0;
    ndone = 0;
    rst_n = 1'b1;
    wait_done();
    check_load(VEC[0][1], VEC[0][0]);
    chk((t1 - t0) == time'(2 * HALF * 10), "R3 SK period", t1 - t0, 2 * HALF * 10);

    for (int v = 1; v < NV; v++) begin
      build(VEC[v][17:2], VEC[v][1], VEC[v][0]);
      nw = 0;
      ndone = 0;
      pulse_reload();
      chk(load_busy == 1'b1, "R12 reload starts load", load_busy, 1);
      wait_done();
      check_load(VEC[v][1], VEC[v][0]);
    end

    // R12: second request while busy is ignored
    build(16'h7E81, 1'b0, 1'b0);
    nw = 0;
    ndone = 0;
    pulse_reload();
    repeat (200) @(negedge clk);
    pulse_reload();
    wait_done();
    chk(sess_rises == 297, "R12 no restart while busy", sess_rises, 297);
    chk(ndone == 1, "R12 single done", ndone, 1);
    check_load(1'b0, 1'b0);

    // R1: reset in the middle of a load
    build(16'h2468, 1'b0, 1'b0);
    pulse_reload();
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({ee_cs, ee_sk, cfg_we, load_done, load_err} == 5'b0, "R1 mid-load reset outputs",
        {ee_cs, ee_sk, cfg_we, load_done, load_err}, 0);
    chk(station_addr == 48'h0, "R1 mid-load reset station", station_addr, 0);
    nw = 0;
    ndone = 0;
    exp_sta = '0;
    rst_n = 1'b1;
    wait_done();
    check_load(1'b0, 1'b0);

    report();
    $finish;
  end
endmodule